// File: doc/BRIEF.md
# Direct Feedback Alignment Gradient Unit

This block produces the weight gradient and the weight update for one spiking layer during on-device training. It does not carry errors back through the transposed forward weights. Instead, it projects the network's output error straight into the layer's error space through a fixed pseudo-random feedback matrix. That matrix is computed from a formula and never changes. The projection is formed once, from a single error beat per sample, and then held. For every timestep of that sample, the block takes one beat of presynaptic spikes and one beat of membrane potentials. It gates the held projection with a rectangular surrogate spike derivative and adds the result into one signed accumulator per synapse.

When the last timestep of the last sample in a batch has been accepted, the block stops taking input. It then walks the synapses in order and, for each one, shifts the accumulated gradient right, subtracts it from the current 4-bit weight and saturates the result. Each new weight leaves through a write port as two 2-bit cell values. The block keeps a mirror of the weights it has written, all zero after reset, and uses it as the old weight of the next update. A one-cycle completion pulse follows the last write.

The controller has three states. ST_WAIT_ERR waits for an error beat. The transition *error accepted* leads to ST_ACCUM. ST_ACCUM takes timestep beats. Its transition *sample end* returns to ST_WAIT_ERR when more samples of the batch remain, and its transition *batch end* enters ST_WRITE. ST_WRITE issues one write per cycle, and its transition *update written* returns to ST_WAIT_ERR.

Top module: `dfa_grad_unit`

## Requirements
- R1: After reset, err_ready is 1, spk_ready, vm_ready, wr_en and done are 0, every weight is 0 and every accumulator is 0.
- R2: The feedback entry for post-neuron j and output k is the low 4 bits of (j*N_OUT+k)*7+3, read as two's complement. The projection is delta[j] = sum over k of entry(j,k)*e[k]. Element k of the error sits in err_data[k*EW +: EW]. The projection is taken once from the accepted error beat and reused at every timestep of the sample. While timesteps are being taken err_ready is 0, so error beats have no effect.
- R3: A timestep is accepted only on a cycle in ST_ACCUM where spk_valid and vm_valid are both 1. A cycle with only one of them high adds nothing.
- R4: The surrogate derivative for post-neuron j is 1 exactly when its potential vm_data[j*VW +: VW] (signed) lies in [VTH-WIN, VTH+WIN], both ends included. Otherwise it is 0.
- R5: On an accepted timestep, the accumulator of synapse (j,i) gains delta[j] when spk_data[i] is 1 and the surrogate of j is 1. Otherwise it is unchanged.
- R6: No weight is written until N_STEPS timesteps of each of BATCH samples have been accepted. Between samples of a batch the block returns to waiting for an error.
- R7: The new weight is w - (acc >>> SHIFT), saturated to [-8, 7]. After its write the accumulator of that synapse is cleared.
- R8: The update writes one weight per cycle at addresses j*N_PRE+i, in ascending order, with wr_hi = w[3:2] and wr_lo = w[1:0]. All input ready signals are 0 while writes are issued.
- R9: done is a single-cycle pulse in the cycle right after the last write of an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Output-error beat valid |
| err_ready | output | 1 | Output-error beat accepted |
| err_data | input | N_OUT*EW (12) | Signed output-error vector |
| spk_valid | input | 1 | Presynaptic spike beat valid |
| spk_ready | output | 1 | Spike beat can be taken |
| spk_data | input | N_PRE (2) | One spike bit per presynaptic input |
| vm_valid | input | 1 | Membrane-potential beat valid |
| vm_ready | output | 1 | Potential beat can be taken |
| vm_data | input | N_POST*VW (16) | Signed potential per post-neuron |
| wr_en | output | 1 | Weight write strobe |
| wr_addr | output | AB (2) | Synapse index j*N_PRE+i |
| wr_hi | output | 2 | Upper cell of the 4-bit weight |
| wr_lo | output | 2 | Lower cell of the 4-bit weight |
| done | output | 1 | Update complete pulse |

## Verification
On every cycle, the assertions check the write burst and its framing. Writes never overlap an open input handshake. Addresses start at zero and step by one. A burst is exactly as long as the synapse count, and done is a lone pulse that closes a full burst. Only the bench's scenarios can show the arithmetic: the feedback projection, the surrogate window edges, the gating by spikes, the reuse of the projection over timesteps and samples, and the shift-and-saturate update in both directions. The bench checks these against its own model of the written weights, including partial handshakes and error beats offered mid-sample, which must leave the results unchanged.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_ERR = 2'd0,
        ST_ACCUM    = 2'd1,
        ST_WRITE    = 2'd2
    } dfa_state_e;

    localparam int FBW = 4;   // feedback entry width
    localparam int WW  = 4;   // weight width (two 2-bit cells)

    // Fixed pseudo-random feedback entry, computed rather than tabulated
    function automatic logic signed [FBW-1:0] fb_entry(input int idx);
        return FBW'(idx * 7 + 3);
    endfunction

endpackage

// File: rtl/dfa_proj.sv
module dfa_proj
    import dfa_pkg::*;
#(
    parameter int N_OUT  = 2,
    parameter int N_POST = 2,
    parameter int EW     = 6,
    parameter int DW     = 11
) (
    input  logic [N_OUT*EW-1:0]  err_data,
    output logic [N_POST*DW-1:0] delta_flat
);

    for (genvar j = 0; j < N_POST; j++) begin : g_row
        logic signed [DW-1:0] sum;
        always_comb begin
            sum = '0;
            for (int k = 0; k < N_OUT; k++) begin
                sum = sum + DW'($signed(err_data[k*EW +: EW])) * DW'(fb_entry(j*N_OUT + k));
            end
        end
        assign delta_flat[j*DW +: DW] = sum;
    end

endmodule

// File: rtl/dfa_surr.sv
module dfa_surr #(
    parameter int N_POST = 2,
    parameter int VW     = 8,
    parameter int VTH    = 16,
    parameter int WIN    = 4
) (
    input  logic [N_POST*VW-1:0] vm_data,
    output logic [N_POST-1:0]    surr
);

    localparam logic signed [VW-1:0] LO = VW'(VTH - WIN);
    localparam logic signed [VW-1:0] HI = VW'(VTH + WIN);

    for (genvar j = 0; j < N_POST; j++) begin : g_win
        logic signed [VW-1:0] v;
        assign v       = vm_data[j*VW +: VW];
        assign surr[j] = (v >= LO) && (v <= HI);
    end

endmodule

// File: rtl/dfa_grad_bank.sv
module dfa_grad_bank
    import dfa_pkg::*;
#(
    parameter int N_POST = 2,
    parameter int N_PRE  = 2,
    parameter int DW     = 11,
    parameter int AW     = 16,
    parameter int SHIFT  = 4,
    parameter int AB     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [N_POST*DW-1:0] delta_flat,
    input  logic [N_POST-1:0]    surr,
    input  logic [N_PRE-1:0]     spk,
    input  logic                 wr_go,
    input  logic [AB-1:0]        wr_idx,
    output logic [WW-1:0]        w_out
);

    localparam int NW   = N_POST * N_PRE;
    localparam int WMAX = 2**(WW-1) - 1;
    localparam int WMIN = -(2**(WW-1));

    logic signed [AW-1:0] acc [NW];
    logic signed [WW-1:0] wt  [NW];
    logic signed [AW-1:0] step_sz;
    logic signed [AW:0]   diff;
    logic signed [WW-1:0] w_new;

    always_comb begin
        step_sz = acc[wr_idx] >>> SHIFT;
        diff    = (AW+1)'(wt[wr_idx]) - (AW+1)'(step_sz);
        if (diff > WMAX)      w_new = WW'(WMAX);
        else if (diff < WMIN) w_new = WW'(WMIN);
        else                  w_new = WW'(diff);
    end

    assign w_out = w_new;

    for (genvar n = 0; n < NW; n++) begin : g_syn
        localparam int J = n / N_PRE;
        localparam int I = n % N_PRE;
        logic signed [AW-1:0] a_q;
        logic signed [WW-1:0] w_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                w_q <= '0;
            end else if (wr_go && wr_idx == AB'(n)) begin
                a_q <= '0;
                w_q <= w_new;
            end else if (step_en && spk[I] && surr[J]) begin
                a_q <= a_q + AW'($signed(delta_flat[J*DW +: DW]));
            end
        end
        assign acc[n] = a_q;
        assign wt[n]  = w_q;
    end

endmodule

// File: rtl/dfa_grad_unit.sv
module dfa_grad_unit
    import dfa_pkg::*;
#(
    parameter int N_OUT   = 2,
    parameter int N_POST  = 2,
    parameter int N_PRE   = 2,
    parameter int N_STEPS = 3,
    parameter int BATCH   = 2,
    parameter int EW      = 6,
    parameter int VW      = 8,
    parameter int VTH     = 16,
    parameter int WIN     = 4,
    parameter int AW      = 16,
    parameter int SHIFT   = 4,
    localparam int NW     = N_POST * N_PRE,
    localparam int AB     = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_valid,
    output logic                 err_ready,
    input  logic [N_OUT*EW-1:0]  err_data,
    input  logic                 spk_valid,
    output logic                 spk_ready,
    input  logic [N_PRE-1:0]     spk_data,
    input  logic                 vm_valid,
    output logic                 vm_ready,
    input  logic [N_POST*VW-1:0] vm_data,
    output logic                 wr_en,
    output logic [AB-1:0]        wr_addr,
    output logic [1:0]           wr_hi,
    output logic [1:0]           wr_lo,
    output logic                 done
);

    localparam int DW = EW + FBW + $clog2(N_OUT);
    localparam int TB = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
    localparam int SB = (BATCH > 1) ? $clog2(BATCH) : 1;

    dfa_state_e            state, state_nx;
    logic [TB-1:0]         step_cnt;
    logic [SB-1:0]         smp_cnt;
    logic [AB-1:0]         addr_cnt;
    logic [N_POST*DW-1:0]  delta_now, delta_q;
    logic [N_POST-1:0]     surr;
    logic [WW-1:0]         w_next;
    logic                  err_fire, step_fire, last_step, last_smp, last_addr;

    assign err_fire  = (state == ST_WAIT_ERR) && err_valid;
    assign step_fire = (state == ST_ACCUM) && spk_valid && vm_valid;
    assign last_step = (step_cnt == TB'(N_STEPS - 1));
    assign last_smp  = (smp_cnt == SB'(BATCH - 1));
    assign last_addr = (addr_cnt == AB'(NW - 1));

    dfa_proj #(.N_OUT(N_OUT), .N_POST(N_POST), .EW(EW), .DW(DW)) u_proj (
        .err_data   (err_data),
        .delta_flat (delta_now)
    );

    dfa_surr #(.N_POST(N_POST), .VW(VW), .VTH(VTH), .WIN(WIN)) u_surr (
        .vm_data (vm_data),
        .surr    (surr)
    );

    dfa_grad_bank #(.N_POST(N_POST), .N_PRE(N_PRE), .DW(DW), .AW(AW),
                    .SHIFT(SHIFT), .AB(AB)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_fire),
        .delta_flat (delta_q),
        .surr       (surr),
        .spk        (spk_data),
        .wr_go      (state == ST_WRITE),
        .wr_idx     (addr_cnt),
        .w_out      (w_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_ERR;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_ERR: if (err_fire) state_nx = ST_ACCUM;
            ST_ACCUM:    if (step_fire && last_step)
                             state_nx = last_smp ? ST_WRITE : ST_WAIT_ERR;
            ST_WRITE:    if (last_addr) state_nx = ST_WAIT_ERR;
            default:     state_nx = ST_WAIT_ERR;
        endcase
    end

    // counters, held projection, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            smp_cnt  <= '0;
            addr_cnt <= '0;
            delta_q  <= '0;
            done     <= 1'b0;
        end else begin
            done <= (state == ST_WRITE) && last_addr;
            if (err_fire) delta_q <= delta_now;
            if (step_fire) begin
                step_cnt <= last_step ? '0 : step_cnt + 1'b1;
                if (last_step) smp_cnt <= last_smp ? '0 : smp_cnt + 1'b1;
            end
            if (state == ST_WRITE) addr_cnt <= last_addr ? '0 : addr_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        err_ready = (state == ST_WAIT_ERR);
        spk_ready = (state == ST_ACCUM);
        vm_ready  = (state == ST_ACCUM);
        wr_en     = (state == ST_WRITE);
        wr_addr   = addr_cnt;
        wr_hi     = w_next[3:2];
        wr_lo     = w_next[1:0];
    end

endmodule

// File: rtl/dfa_grad_unit_chk.sv
module dfa_grad_unit_chk #(
    parameter int NW = 4,
    parameter int AB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          err_ready,
    input logic          spk_ready,
    input logic          vm_ready,
    input logic          wr_en,
    input logic [AB-1:0] wr_addr,
    input logic          done
);

    logic [15:0] run;
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= wr_en ? run + 1'b1 : '0;
    end

    // R8
    write_stalls_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!err_ready && !spk_ready && !vm_ready));

    // R2
    err_closed_in_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_ready && spk_ready));

    // R8
    addr_starts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (wr_addr == '0));

    // R8
    addr_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == AB'($past(wr_addr) + 1'b1)));

    // R8
    burst_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (run < 16'(NW)));

    // R9
    done_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run == 16'(NW) && !wr_en));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind dfa_grad_unit dfa_grad_unit_chk #(.NW(NW), .AB(AB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_ready (err_ready),
    .spk_ready (spk_ready),
    .vm_ready  (vm_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done)
);

// File: tb/dfa_grad_unit_bench.sv
module dfa_grad_unit_bench;

    localparam int N_OUT = 2, N_POST = 2, N_PRE = 2, T = 3, NW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic err_valid = 0, spk_valid = 0, vm_valid = 0;
    logic [11:0] err_data = '0;
    logic [1:0]  spk_data = '0;
    logic [15:0] vm_data = '0;
    logic err_ready, spk_ready, vm_ready, wr_en, done;
    logic [1:0] wr_addr, wr_hi, wr_lo;

    always #10 clk = ~clk;   // 50 MHz

    dfa_grad_unit u_dfa_grad_unit (
        .clk(clk), .rst_n(rst_n),
        .err_valid(err_valid), .err_ready(err_ready), .err_data(err_data),
        .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_data(spk_data),
        .vm_valid(vm_valid), .vm_ready(vm_ready), .vm_data(vm_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .done(done)
    );

    // sample table: error vector, spike bits per step, potentials per step
    localparam int ERR_T [4][2] = '{'{20, -13}, '{-7, 25}, '{31, -32}, '{5, 9}};
    localparam int SPK_T [4][3] = '{'{3, 1, 2}, '{1, 3, 3}, '{3, 3, 0}, '{2, 1, 3}};
    localparam int VM_T  [4][3][2] = '{
        '{'{16, 12}, '{20, 11}, '{21, -5}},
        '{'{14, 30}, '{12, 20}, '{100, 19}},
        '{'{16, 16}, '{-12, 17}, '{16, 16}},
        '{'{13, 13}, '{19, 21}, '{20, 12}}};

    int checks = 0, errors = 0;
    int mw [NW];
    int macc [NW];
    int cur_e [2];
    int cur_spk [3];
    int cur_vm [3][2];
    bit glitch = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fbv(input int idx);
        int v;
        v = (idx * 7 + 3) & 15;
        return (v >= 8) ? v - 16 : v;
    endfunction

    task automatic send_err();
        @(negedge clk);
        err_valid = 1;
        err_data  = {6'(cur_e[1]), 6'(cur_e[0])};
        #1;
        while (!err_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        err_valid = 0;
    endtask

    task automatic step_beat(input int t);
        @(negedge clk);
        spk_valid = 1; vm_valid = 1;
        spk_data  = 2'(cur_spk[t]);
        vm_data   = {8'(cur_vm[t][1]), 8'(cur_vm[t][0])};
        #1;
        while (!(spk_ready && vm_ready)) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        spk_valid = 0; vm_valid = 0;
    endtask

    // R3 / R2: partial handshakes and a stray error beat must not count
    task automatic glitch_cycles();
        @(negedge clk);
        spk_valid = 1; vm_valid = 0; spk_data = 2'b11; vm_data = {8'd16, 8'd16};
        err_valid = 1; err_data = {6'd31, 6'd31};
        #1;
        chk("R2", "err_ready while taking steps", int'(err_ready), 0);
        @(negedge clk);
        @(negedge clk);
        spk_valid = 0; vm_valid = 1;
        #1;
        chk("R3", "spk_ready held in accumulate", int'(spk_ready), 1);
        @(negedge clk);
        vm_valid = 0; err_valid = 0;
    endtask

    task automatic run_sample();
        int d [2];
        for (int j = 0; j < N_POST; j++) begin
            d[j] = 0;
            for (int k = 0; k < N_OUT; k++) d[j] += fbv(j * N_OUT + k) * cur_e[k];
        end
        for (int t = 0; t < T; t++)
            for (int j = 0; j < N_POST; j++)
                for (int i = 0; i < N_PRE; i++)
                    if (((cur_spk[t] >> i) & 1) == 1 && cur_vm[t][j] >= 12 && cur_vm[t][j] <= 20)
                        macc[j * N_PRE + i] += d[j];
        send_err();
        if (glitch) glitch_cycles();
        for (int t = 0; t < T; t++) step_beat(t);
    endtask

    task automatic check_update(input string tag);
        int nw, x;
        @(negedge clk);
        chk("R8", "err_ready during writes", int'(err_ready), 0);
        chk("R8", "spk_ready during writes", int'(spk_ready), 0);
        for (int k = 0; k < NW; k++) begin
            nw = mw[k] - (macc[k] >>> 4);
            if (nw > 7) nw = 7;
            if (nw < -8) nw = -8;
            mw[k] = nw; macc[k] = 0;
            x = nw & 15;
            chk("R8", {tag, " wr_en"}, int'(wr_en), 1);
            chk("R8", {tag, " wr_addr"}, int'(wr_addr), k);
            chk("R7", {tag, " weight cells"}, int'({wr_hi, wr_lo}), x);
            @(negedge clk);
        end
        chk("R9", {tag, " done after last write"}, int'(done), 1);
        chk("R9", {tag, " wr_en off after burst"}, int'(wr_en), 0);
        @(negedge clk);
        chk("R9", {tag, " done one cycle"}, int'(done), 0);
    endtask

    task automatic fill_const(input int e0, input int e1);
        cur_e[0] = e0; cur_e[1] = e1;
        for (int t = 0; t < T; t++) begin
            cur_spk[t] = 3; cur_vm[t][0] = 16; cur_vm[t][1] = 16;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NW; k++) begin mw[k] = 0; macc[k] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "err_ready in reset", int'(err_ready), 1);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1", "err_ready after reset", int'(err_ready), 1);
        chk("R1", "spk_ready after reset", int'(spk_ready), 0);
        chk("R1", "vm_ready after reset", int'(vm_ready), 0);
        chk("R1", "wr_en after reset", int'(wr_en), 0);
        chk("R1", "done after reset", int'(done), 0);

        // table walk: R2 R4 R5 projection, window edges 12/20 in, 11/21 out
        for (int s = 0; s < 4; s++) begin
            cur_e[0] = ERR_T[s][0]; cur_e[1] = ERR_T[s][1];
            for (int t = 0; t < T; t++) begin
                cur_spk[t] = SPK_T[s][t];
                cur_vm[t][0] = VM_T[s][t][0];
                cur_vm[t][1] = VM_T[s][t][1];
            end
            glitch = (s == 2);
            run_sample();
            glitch = 0;
            if (s % 2 == 1) begin
                check_update("R5 table batch");
            end else begin
                @(negedge clk);
                chk("R6", "no write mid-batch", int'(wr_en), 0);
                chk("R6", "waits for next error", int'(err_ready), 1);
            end
        end

        // R7 positive saturation: every weight driven to +7
        fill_const(31, 31); run_sample();
        @(negedge clk);
        chk("R6", "no write after first sample", int'(wr_en), 0);
        fill_const(31, 31); run_sample();
        check_update("R7 saturate high");
        chk("R7", "weight 0 at +7", mw[0], 7);

        // R7 negative saturation: every weight driven to -8
        fill_const(-32, -32); run_sample();
        fill_const(-32, -32); run_sample();
        check_update("R7 saturate low");
        chk("R7", "weight 3 at -8", mw[3], -8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule